// File: doc/BRIEF.md
# Write-Once Keyed Service Watchdog

This block is a memory-mapped system watchdog. Software writes a single control word after power-on that fixes the timeout reload value, turns the timer on, picks between reset and interrupt on expiry, selects prescaling and allows the timer to stop for debug. Once that word has been accepted, the control register is locked. Only a power-on reset or a system reset unlocks it.

While the timer is on, a down-counter is decremented on prescaled ticks. To restart it from the timeout value, software writes the two 16-bit keys 0x556C and 0xAA39, in that order, to the service register. When the count reaches zero, the block raises either a reset request or an interrupt request and holds it. A reset request also sets a sticky cause flag. That flag survives the system reset the request triggers, and software clears it by writing a 1 to it.

Top module: `wdt_keyed`

## Requirements
- R1: The control register is at offset 0x04. It reads back the timeout in bits 31:16, freeze in bit 3, enable in bit 2, reset-select in bit 1 and prescale in bit 0. All other bits read 0, and the whole register reads 0 after reset.
- R2: Only the first control write after a power-on or system reset is accepted. Every later control write leaves the register and the counter untouched.
- R3: A control write with bit 2 set loads the counter from the timeout field, and a timeout of 0 loads 65536. The counter's live value reads at offset 0x08.
- R4: Each tick decrements the counter by one, and the counter stops at 0. With prescale clear, every clock is a tick. With it set, one tick comes every 65536 clocks, or every 2048 clocks when SMALL_PRESCALE is 1.
- R5: Writing 0x556C and then 0xAA39 in bits 15:0 to offset 0x0E reloads the counter from the timeout field. When the reload falls in the same cycle as a decrement, the reload wins.
- R6: A service write that is not the next expected key returns the sequence to its start and does not reload. This covers a stray value after the first key, a repeated first key and a lone second key.
- R7: Writes to the count register have no effect on the count.
- R8: While the block is enabled and the count is 0, rst_req is high if reset-select is 1 and irq_req is high if it is 0. The request stays high until the next reload. The two requests are never high together.
- R9: While freeze is set and dbg_halt is high, the counter holds. With freeze clear, dbg_halt has no effect.
- R10: The cause flag is bit 0 at offset 0x10. It is set in the cycle after rst_req is high and survives sys_rst_n. Writing 1 clears it, writing 0 does not, and por_n clears it.
- R11: If the accepted control write leaves enable clear, the counter stays at 0 and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | System reset, active low, clears all but the cause flag |
| dbg_halt | input | 1 | Debug halt, stops counting when freeze is set |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high with bus_sel |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rst_req | output | 1 | Expiry request for a system reset |
| irq_req | output | 1 | Expiry request for an interrupt |

## Verification
The key clash is a service reload that lands on the very tick that would take the count from 1 to 0. The bench times the first key so that the closing key 0xAA39 is clocked on that edge. It then expects the full timeout value in the count register, with irq_req low. A second clash sets the cause flag against a write-1 clear. Neither bench nor checker stages it directly; the checker's property that a request is followed by a set flag covers it.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

   localparam int TIMEOUT_W = 16;
   localparam int CNT_W     = TIMEOUT_W + 1;

   localparam logic [15:0] KEY_ARM  = 16'h556C;
   localparam logic [15:0] KEY_FIRE = 16'hAA39;

   typedef struct packed {
      logic [TIMEOUT_W-1:0] timeout;
      logic                 freeze;
      logic                 enable;
      logic                 rst_sel;
      logic                 presc;
   } wdt_ctrl_t;

   typedef enum logic {
      SEQ_IDLE  = 1'b0,
      SEQ_ARMED = 1'b1
   } seq_state_t;

   function automatic wdt_ctrl_t word_to_ctrl(input logic [31:0] w);
      wdt_ctrl_t c;
      c.timeout = w[31:16];
      c.freeze  = w[3];
      c.enable  = w[2];
      c.rst_sel = w[1];
      c.presc   = w[0];
      return c;
   endfunction

   function automatic logic [31:0] ctrl_to_word(input wdt_ctrl_t c);
      return {c.timeout, 12'h000, c.freeze, c.enable, c.rst_sel, c.presc};
   endfunction

   // timeout field of zero stands for a full 2^TIMEOUT_W ticks
   function automatic logic [CNT_W-1:0] reload_of(input logic [TIMEOUT_W-1:0] t);
      if (t == '0) return {1'b1, {TIMEOUT_W{1'b0}}};
      return {1'b0, t};
   endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
   parameter int DIV_LOG2 = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   input  logic bypass,
   output logic tick
);
   logic [DIV_LOG2-1:0] acc;

   assign tick = run & (bypass | (&acc));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               acc <= '0;
      else if (clear)           acc <= '0;
      else if (run && !bypass)  acc <= acc + 1'b1;
   end
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
   import wdt_keyed_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [15:0] data,
   output logic        fire
);
   seq_state_t state, state_nx;

   always_comb begin
      state_nx = state;
      fire     = 1'b0;
      if (wr) begin
         state_nx = SEQ_IDLE;
         if (state == SEQ_IDLE && data == KEY_ARM)
            state_nx = SEQ_ARMED;
         else if (state == SEQ_ARMED && data == KEY_FIRE)
            fire = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= SEQ_IDLE;
      else        state <= state_nx;
   end
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
   parameter int W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         tick,
   output logic [W-1:0] cnt,
   output logic         zero
);
   assign zero = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= load_val;
      else if (tick && !zero) cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
   import wdt_keyed_pkg::*;
#(
   parameter int          ADDR_W         = 5,
   parameter bit          SMALL_PRESCALE = 1'b0,
   parameter logic [7:0]  OFF_CTRL       = 8'h04,
   parameter logic [7:0]  OFF_COUNT      = 8'h08,
   parameter logic [7:0]  OFF_SVC        = 8'h0E,
   parameter logic [7:0]  OFF_STAT       = 8'h10
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              dbg_halt,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              rst_req,
   output logic              irq_req
);
   localparam int DIV_LOG2 = SMALL_PRESCALE ? 11 : 16;

   if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr_w
      $error("wdt_keyed: ADDR_W must lie in 5..8");
   end
   if (OFF_STAT >= (8'(1) << ADDR_W)) begin : g_bad_off
      $error("wdt_keyed: status offset outside address space");
   end

   logic blk_rst_n;
   assign blk_rst_n = por_n & sys_rst_n;

   // address decode
   logic wr_ctrl, wr_svc, wr_stat;
   assign wr_ctrl = bus_sel & bus_wr & (bus_addr == OFF_CTRL[ADDR_W-1:0]);
   assign wr_svc  = bus_sel & bus_wr & (bus_addr == OFF_SVC[ADDR_W-1:0]);
   assign wr_stat = bus_sel & bus_wr & (bus_addr == OFF_STAT[ADDR_W-1:0]);

   // write-once control
   wdt_ctrl_t ctrl_q;
   logic      locked;
   logic      ctrl_take;
   wdt_ctrl_t ctrl_new;

   assign ctrl_new  = word_to_ctrl(bus_wdata);
   assign ctrl_take = wr_ctrl & ~locked;

   always_ff @(posedge clk or negedge blk_rst_n) begin
      if (!blk_rst_n) begin
         ctrl_q <= '0;
         locked <= 1'b0;
      end else if (ctrl_take) begin
         ctrl_q <= ctrl_new;
         locked <= 1'b1;
      end
   end

   // service key sequence
   logic svc_fire;
   wdt_key_seq u_keys (
      .clk   (clk),
      .rst_n (blk_rst_n),
      .wr    (wr_svc),
      .data  (bus_wdata[15:0]),
      .fire  (svc_fire)
   );

   // counter load sources
   logic             arm_load, reload, cnt_load;
   logic [CNT_W-1:0] load_val;
   assign arm_load = ctrl_take & ctrl_new.enable;
   assign reload   = svc_fire & ctrl_q.enable;
   assign cnt_load = arm_load | reload;
   assign load_val = arm_load ? reload_of(ctrl_new.timeout) : reload_of(ctrl_q.timeout);

   logic [CNT_W-1:0] cnt;
   logic             cnt_zero;
   logic             run, tick;

   assign run = ctrl_q.enable & ~(ctrl_q.freeze & dbg_halt) & ~cnt_zero;

   if (DIV_LOG2 == 11) begin : g_pre_small
      wdt_prescaler #(.DIV_LOG2(11)) u_pre (
         .clk(clk), .rst_n(blk_rst_n), .clear(cnt_load),
         .run(run), .bypass(~ctrl_q.presc), .tick(tick));
   end else begin : g_pre_full
      wdt_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
         .clk(clk), .rst_n(blk_rst_n), .clear(cnt_load),
         .run(run), .bypass(~ctrl_q.presc), .tick(tick));
   end

   wdt_down_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (blk_rst_n),
      .load     (cnt_load),
      .load_val (load_val),
      .tick     (tick),
      .cnt      (cnt),
      .zero     (cnt_zero)
   );

   // expiry requests
   logic expired;
   assign expired = ctrl_q.enable & cnt_zero;
   assign rst_req = expired & ctrl_q.rst_sel;
   assign irq_req = expired & ~ctrl_q.rst_sel;

   // sticky cause flag, power-on reset only
   logic cause_flag;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                        cause_flag <= 1'b0;
      else if (rst_req)                  cause_flag <= 1'b1;
      else if (wr_stat && bus_wdata[0])  cause_flag <= 1'b0;
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == OFF_CTRL[ADDR_W-1:0])
         bus_rdata = ctrl_to_word(ctrl_q);
      else if (bus_addr == OFF_COUNT[ADDR_W-1:0])
         bus_rdata = {{(32-CNT_W){1'b0}}, cnt};
      else if (bus_addr == OFF_STAT[ADDR_W-1:0])
         bus_rdata = {31'b0, cause_flag};
   end

   logic unused_wdata;
   assign unused_wdata = ^{bus_wdata[15:4]};
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
   import wdt_keyed_pkg::*;
(
   input logic             clk,
   input logic             por_n,
   input logic             sys_rst_n,
   input logic             dbg_halt,
   input logic             wr_ctrl,
   input logic             locked,
   input wdt_ctrl_t        ctrl_q,
   input logic [CNT_W-1:0] cnt,
   input logic             cnt_load,
   input logic             svc_fire,
   input logic             rst_req,
   input logic             irq_req,
   input logic             cause_flag
);
   // R2
   lock_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      (locked && wr_ctrl) |=> $stable(ctrl_q));

   // R4
   no_rise_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      !cnt_load |=> (cnt <= $past(cnt)));

   // R5
   reload_val_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      (svc_fire && ctrl_q.enable) |=> (cnt == reload_of($past(ctrl_q.timeout))));

   // R8
   req_excl_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      !(rst_req && irq_req));

   // R9
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      (ctrl_q.freeze && dbg_halt && !cnt_load) |=> $stable(cnt));

   // R10
   flag_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      rst_req |=> cause_flag);
endmodule

bind wdt_keyed wdt_keyed_chk u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .sys_rst_n  (sys_rst_n),
   .dbg_halt   (dbg_halt),
   .wr_ctrl    (wr_ctrl),
   .locked     (locked),
   .ctrl_q     (ctrl_q),
   .cnt        (cnt),
   .cnt_load   (cnt_load),
   .svc_fire   (svc_fire),
   .rst_req    (rst_req),
   .irq_req    (irq_req),
   .cause_flag (cause_flag)
);

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;
   localparam int AW = 5;
   localparam logic [AW-1:0] A_CTRL = 5'h04, A_CNT = 5'h08, A_SVC = 5'h0E, A_STAT = 5'h10;

   logic          clk = 1'b0;
   logic          por_n = 1'b0, sys_rst_n = 1'b1, dbg_halt = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          rst_req, irq_req;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   wdt_keyed #(.ADDR_W(AW), .SMALL_PRESCALE(1'b1)) u_dut (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .dbg_halt(dbg_halt),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rst_req(rst_req), .irq_req(irq_req));

   function automatic logic [31:0] mk(input logic [15:0] t, input logic frz,
                                       input logic en, input logic rs, input logic pre);
      return {t, 12'h000, frz, en, rs, pre};
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // call at a falling edge; the access is clocked on the next rising edge
   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic power_on();
      por_n = 1'b0; sys_rst_n = 1'b1; dbg_halt = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      power_on();
      rd(A_CTRL, d); chk("R1 ctrl after reset", d, 32'h0);
      rd(A_CNT, d);  chk("R3 count after reset", d, 32'h0);
      rd(A_STAT, d); chk("R10 flag after por", d, 32'h0);
      chk("R8 no request after reset", {30'h0, rst_req, irq_req}, 32'h0);
   endtask

   task automatic t_irq_countdown();
      logic [31:0] d;
      power_on();
      dbg_halt = 1'b1;                          // freeze clear: no effect (R9)
      wr(A_CTRL, mk(16'd5, 1'b0, 1'b1, 1'b0, 1'b0) | 32'h0000_FFF0);
      rd(A_CTRL, d); chk("R1 ctrl readback masked", d, mk(16'd5, 1'b0, 1'b1, 1'b0, 1'b0));
      rd(A_CNT, d);  chk("R3 load on enable", d, 32'd5);
      wr(A_CTRL, mk(16'd99, 1'b0, 1'b0, 1'b1, 1'b1));
      rd(A_CTRL, d); chk("R2 second ctrl write ignored", d, mk(16'd5, 1'b0, 1'b1, 1'b0, 1'b0));
      rd(A_CNT, d);  chk("R4 R9 decrement per clock with halt", d, 32'd4);
      repeat (3) @(negedge clk);
      rd(A_CNT, d);  chk("R4 count before expiry", d, 32'd1);
      chk("R8 irq low before expiry", {31'h0, irq_req}, 32'h0);
      @(negedge clk);
      rd(A_CNT, d);  chk("R4 count at expiry", d, 32'd0);
      chk("R8 irq mode request", {30'h0, rst_req, irq_req}, 32'h1);
      repeat (3) @(negedge clk);
      rd(A_CNT, d);  chk("R4 count sticks at zero", d, 32'd0);
      chk("R8 irq held", {31'h0, irq_req}, 32'h1);
      dbg_halt = 1'b0;
   endtask

   task automatic t_service();
      logic [31:0] d;
      power_on();
      wr(A_CTRL, mk(16'd20, 1'b0, 1'b1, 1'b0, 1'b0));
      repeat (5) @(negedge clk);
      wr(A_SVC, 32'h556C);
      wr(A_SVC, 32'hAA39);
      rd(A_CNT, d); chk("R5 key pair reloads", d, 32'd20);
      wr(A_SVC, 32'h556C); wr(A_SVC, 32'h1234); wr(A_SVC, 32'hAA39);
      rd(A_CNT, d); chk("R6 stray value breaks sequence", d, 32'd17);
      wr(A_SVC, 32'h556C); wr(A_SVC, 32'h556C); wr(A_SVC, 32'hAA39);
      rd(A_CNT, d); chk("R6 repeated first key", d, 32'd14);
      wr(A_SVC, 32'hAA39);
      rd(A_CNT, d); chk("R6 lone second key", d, 32'd13);
      wr(A_CNT, 32'h0000_1234);
      rd(A_CNT, d); chk("R7 count write ignored", d, 32'd12);
      wr(A_SVC, 32'h556C); wr(A_SVC, 32'hAA39);
      rd(A_CNT, d); chk("R5 reload after restart", d, 32'd20);
   endtask

   task automatic t_clash();
      logic [31:0] d;
      power_on();
      wr(A_CTRL, mk(16'd4, 1'b0, 1'b1, 1'b0, 1'b0));
      repeat (2) @(negedge clk);
      wr(A_SVC, 32'h556C);                     // count goes 2 -> 1
      wr(A_SVC, 32'hAA39);                     // edge that would reach 0
      rd(A_CNT, d); chk("R5 reload beats final tick", d, 32'd4);
      chk("R8 no irq on clash", {31'h0, irq_req}, 32'h0);
   endtask

   task automatic t_reset_mode();
      logic [31:0] d;
      power_on();
      wr(A_CTRL, mk(16'd3, 1'b0, 1'b1, 1'b1, 1'b0));
      repeat (3) @(negedge clk);
      chk("R8 reset mode request", {30'h0, rst_req, irq_req}, 32'h2);
      @(negedge clk);
      rd(A_STAT, d); chk("R10 flag set", d, 32'h1);
      sys_rst_n = 1'b0;
      @(negedge clk);
      chk("R8 request cleared by sys reset", {31'h0, rst_req}, 32'h0);
      sys_rst_n = 1'b1;
      @(negedge clk);
      rd(A_STAT, d); chk("R10 flag survives sys reset", d, 32'h1);
      rd(A_CTRL, d); chk("R2 ctrl cleared by sys reset", d, 32'h0);
      wr(A_STAT, 32'h0);
      rd(A_STAT, d); chk("R10 write 0 keeps flag", d, 32'h1);
      wr(A_STAT, 32'h1);
      rd(A_STAT, d); chk("R10 write 1 clears flag", d, 32'h0);
      wr(A_CTRL, mk(16'd7, 1'b0, 1'b1, 1'b1, 1'b0));
      rd(A_CNT, d);  chk("R2 rearmed after sys reset", d, 32'd7);
   endtask

   task automatic t_disabled();
      logic [31:0] d;
      power_on();
      wr(A_CTRL, mk(16'd2, 1'b0, 1'b0, 1'b0, 1'b0));
      wr(A_CTRL, mk(16'd2, 1'b0, 1'b1, 1'b0, 1'b0));
      wr(A_SVC, 32'h556C); wr(A_SVC, 32'hAA39);
      repeat (10) @(negedge clk);
      rd(A_CTRL, d); chk("R11 enable stays off", d, mk(16'd2, 1'b0, 1'b0, 1'b0, 1'b0));
      rd(A_CNT, d);  chk("R11 count idle", d, 32'd0);
      chk("R11 no request", {30'h0, rst_req, irq_req}, 32'h0);
   endtask

   task automatic t_zero_timeout();
      logic [31:0] d;
      power_on();
      wr(A_CTRL, mk(16'd0, 1'b0, 1'b1, 1'b0, 1'b0));
      rd(A_CNT, d); chk("R3 zero timeout gives 65536", d, 32'h0001_0000);
   endtask

   task automatic t_prescale();
      logic [31:0] d;
      power_on();
      wr(A_CTRL, mk(16'd2, 1'b0, 1'b1, 1'b0, 1'b1));
      repeat (2047) @(negedge clk);
      rd(A_CNT, d); chk("R4 prescale holds 2047 clocks", d, 32'd2);
      @(negedge clk);
      rd(A_CNT, d); chk("R4 prescale tick at 2048", d, 32'd1);
   endtask

   task automatic t_freeze();
      logic [31:0] d;
      power_on();
      wr(A_CTRL, mk(16'd10, 1'b1, 1'b1, 1'b0, 1'b0));
      dbg_halt = 1'b1;
      repeat (4) @(negedge clk);
      rd(A_CNT, d); chk("R9 frozen while halted", d, 32'd10);
      dbg_halt = 1'b0;
      @(negedge clk);
      rd(A_CNT, d); chk("R9 resumes after halt", d, 32'd9);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired checks=%0d", checks);
      summary();
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_irq_countdown();
      t_service();
      t_clash();
      t_reset_mode();
      t_disabled();
      t_zero_timeout();
      t_prescale();
      t_freeze();
      summary();
      $finish;
   end
endmodule